// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Timebase

This block generates the switching pulse for a switching power converter. A free-running period counter starts a new switching cycle at a fixed rate, 1000 clock cycles by default, which is 100 kHz from a 100 MHz clock. At each cycle start an on-state latch turns the gate on. Four conditions end the on-time: the PWM comparator, the soft-start comparator, the current-limit comparator, and a built-in cap at three quarters of the period.

A comparator input clears the gate in the same cycle it rises, through logic only, with no wait for a clock edge. The gate then stays off until the next cycle start. A comparator that is active in the cycle start itself overrides the set, so the gate stays off for that whole switching cycle.

When the jitter-enable input is high, the period moves along a slow triangle around its nominal value to spread the switching spectrum. The offset moves one clock cycle at a time between +JIT_SPAN and -JIT_SPAN. By default this is ±40 cycles (±4 %), with one step every JIT_DIV periods. When jitter-enable is low, the period is nominal.

Top module: `jitter_pwm`

## Requirements
- R1: While rst_i is high, gate_o and cyc_start_o are both 0. In the first cycle after reset is released, cyc_start_o is 1 and the first period has NOM_PERIOD cycles.
- R2: With jit_en_i held low, the spacing between consecutive cyc_start_o pulses is exactly NOM_PERIOD clock cycles.
- R3: cyc_start_o is high for exactly one clock cycle per switching period. gate_o only rises in a cycle where cyc_start_o is high.
- R4: With no termination, gate_o is high from the cycle start onward. A 1 on pwm_cmp_i, ss_cmp_i or ilim_i forces gate_o to 0 in that same cycle. gate_o then stays 0 until the next cycle start, even after the input returns to 0. A comparator pulse k cycles after the start (k counting from 0) gives an on-time of min(k, cap) cycles.
- R5: A termination input that is high in the cycle-start cycle wins over the set, and gate_o stays 0 for that entire period.
- R6: In a period of P cycles, the on-time never exceeds floor(P/2)+floor(P/4) cycles. Without termination, it equals exactly that value.
- R7: While jit_en_i is high, the period moves along a triangle. After each group of JIT_DIV periods, the offset changes by one. It rises from 0 to +JIT_SPAN, falls to -JIT_SPAN, and rises again. The period equals NOM_PERIOD plus the offset.
- R8: jit_en_i is sampled at the end of each period. If it is low there, the next period is NOM_PERIOD and the offset restarts at 0 going upward. Enabling jitter again therefore first gives NOM_PERIOD+1.
- R9: Every period length lies between NOM_PERIOD-JIT_SPAN and NOM_PERIOD+JIT_SPAN inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| jit_en_i | input | 1 | Enables period jitter (high after soft start ends) |
| pwm_cmp_i | input | 1 | PWM comparator trip, active high |
| ss_cmp_i | input | 1 | Soft-start comparator trip, active high |
| ilim_i | input | 1 | Current-limit comparator trip, active high |
| gate_o | output | 1 | Gate drive output |
| cyc_start_o | output | 1 | One-cycle pulse at the start of each switching period |

## Verification
The assertions check four things on every cycle:
- a comparator trip never coexists with a high gate;
- the gate only rises at a cycle start;
- the start pulse is a single cycle;
- each completed period has an in-range length and an on-time within three quarters of it.

The exact on-time for a trip at each offset, the set-versus-reset priority in the start cycle, the triangular sequence of period lengths and its restart when jitter is disabled are shown only by the bench's sweeps. The bench compares these against arithmetic expectations.

// File: rtl/jitter_pwm.sv
module jitter_pwm #(
  parameter int NOM_PERIOD = 1000,
  parameter int JIT_SPAN   = 40,
  parameter int JIT_DIV    = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic jit_en_i,
  input  logic pwm_cmp_i,
  input  logic ss_cmp_i,
  input  logic ilim_i,
  output logic gate_o,
  output logic cyc_start_o
);
  localparam int CW = $clog2(NOM_PERIOD + JIT_SPAN + 1);
  localparam int OW = $clog2(JIT_SPAN + 1) + 1;
  localparam int DW = (JIT_DIV > 1) ? $clog2(JIT_DIV) : 1;
  localparam logic signed [OW-1:0] SPAN_S = OW'(JIT_SPAN);

  logic [CW-1:0] cnt, per, max_on;
  logic signed [OW-1:0] off, off_n;
  logic dn, dn_n, lat, wrap, step, stop;
  logic [DW-1:0] div;
  logic signed [31:0] per_calc;

  assign wrap   = (cnt == per - CW'(1));
  assign step   = jit_en_i && (div == DW'(JIT_DIV - 1));
  assign max_on = {1'b0, per[CW-1:1]} + {2'b00, per[CW-1:2]};
  assign stop   = pwm_cmp_i | ss_cmp_i | ilim_i | (cnt >= max_on);

  assign cyc_start_o = (cnt == '0) & ~rst_i;
  assign gate_o      = (cyc_start_o | lat) & ~stop & ~rst_i;

  always_comb begin
    off_n = off;
    dn_n  = dn;
    if (!jit_en_i) begin
      off_n = '0;
      dn_n  = 1'b0;
    end else if (step) begin
      if (!dn) begin
        off_n = off + OW'(1);
        if (off_n == SPAN_S) dn_n = 1'b1;
      end else begin
        off_n = off - OW'(1);
        if (off_n == -SPAN_S) dn_n = 1'b0;
      end
    end
  end

  assign per_calc = 32'(NOM_PERIOD) + 32'(off_n);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt <= '0;
      per <= CW'(NOM_PERIOD);
      off <= '0;
      dn  <= 1'b0;
      div <= '0;
      lat <= 1'b0;
    end else begin
      lat <= gate_o;
      cnt <= wrap ? '0 : cnt + CW'(1);
      if (wrap) begin
        off <= off_n;
        dn  <= dn_n;
        div <= (!jit_en_i || step) ? '0 : div + DW'(1);
        per <= per_calc[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/jitter_pwm_chk.sv
module jitter_pwm_chk #(
  parameter int NOM_PERIOD = 1000,
  parameter int JIT_SPAN   = 40
) (
  input logic clk_i,
  input logic rst_i,
  input logic pwm_cmp_i,
  input logic ss_cmp_i,
  input logic ilim_i,
  input logic gate_o,
  input logic cyc_start_o
);
  int  len, on;
  logic seen;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      len <= 0;
      on <= 0;
      seen <= 1'b0;
    end else if (cyc_start_o) begin
      len <= 1;
      on <= gate_o ? 1 : 0;
      seen <= 1'b1;
    end else begin
      len <= len + 1;
      on <= on + (gate_o ? 1 : 0);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) a_r1_quiet_in_reset: assert (!gate_o && !cyc_start_o);
  end

  a_r3_single_start: assert property (@(posedge clk_i) disable iff (rst_i)
    cyc_start_o |=> !cyc_start_o);

  a_r3_rise_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(gate_o) |-> cyc_start_o);

  a_r4_trip_blocks_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    (pwm_cmp_i || ss_cmp_i || ilim_i) |-> !gate_o);

  a_r6_duty_cap: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_start_o && seen) |-> (on * 4 <= len * 3));

  a_r9_period_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (cyc_start_o && seen) |-> (len >= NOM_PERIOD - JIT_SPAN && len <= NOM_PERIOD + JIT_SPAN));
endmodule

bind jitter_pwm jitter_pwm_chk #(.NOM_PERIOD(NOM_PERIOD), .JIT_SPAN(JIT_SPAN)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .pwm_cmp_i(pwm_cmp_i), .ss_cmp_i(ss_cmp_i),
  .ilim_i(ilim_i), .gate_o(gate_o), .cyc_start_o(cyc_start_o)
);

// File: tb/jitter_pwm_tb_top.sv
module jitter_pwm_tb_top;
  localparam int NOM  = 40;
  localparam int SPAN = 4;

  logic clk = 1'b0, rst = 1'b1, jit = 1'b0, pwm = 1'b0, ss = 1'b0, ilim = 1'b0;
  logic gate, cst;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  jitter_pwm #(.NOM_PERIOD(NOM), .JIT_SPAN(SPAN), .JIT_DIV(1)) dut_i (
    .clk_i(clk), .rst_i(rst), .jit_en_i(jit), .pwm_cmp_i(pwm), .ss_cmp_i(ss),
    .ilim_i(ilim), .gate_o(gate), .cyc_start_o(cst)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap(input int p);
    return (p >> 1) + (p >> 2);
  endfunction

  task automatic run_cycle(input int k, input int src, output int on, output int len, output int late_rise);
    logic prev;
    on = 0; len = 0; late_rise = 0; prev = 1'b0;
    forever begin
      if (cst && len > 0) break;
      pwm  = (len == k) && (src == 0);
      ss   = (len == k) && (src == 1);
      ilim = (len == k) && (src == 2);
      #1;
      if (gate) on++;
      if (gate && !prev && len > 0) late_rise++;
      prev = gate;
      len++;
      @(negedge clk);
      pwm = 1'b0; ss = 1'b0; ilim = 1'b0;
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int on, len, lr, off, exp_p;
    logic dn;
    repeat (3) begin
      @(negedge clk); #1;
      check("R1 gate in reset", gate, 0);
      check("R1 start in reset", cst, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 first start", cst, 1);

    for (int i = 0; i < 3; i++) begin
      run_cycle(-1, 3, on, len, lr);
      check("R2 nominal period", len, NOM);
      check("R6 full on-time", on, cap(NOM));
      check("R3 rise only at start", lr, 0);
    end

    for (int src = 0; src < 3; src++) begin
      for (int k = 0; k < NOM + 2; k++) begin
        run_cycle(k, src, on, len, lr);
        check("R2 period under trip", len, NOM);
        if (k == 0) check("R5 trip at start keeps gate off", on, 0);
        else check("R4 on-time vs trip offset", on, (k < cap(NOM)) ? k : cap(NOM));
        check("R3 no re-rise", lr, 0);
      end
    end

    jit = 1'b1; off = 0; dn = 1'b0; exp_p = NOM;
    for (int i = 0; i < 40; i++) begin
      run_cycle(-1, 3, on, len, lr);
      check("R7 jittered period", len, exp_p);
      check("R6 cap at jittered period", on, cap(exp_p));
      check("R9 range", (len >= NOM - SPAN && len <= NOM + SPAN) ? 1 : 0, 1);
      if (!dn) begin off++; if (off == SPAN) dn = 1'b1; end
      else begin off--; if (off == -SPAN) dn = 1'b0; end
      exp_p = NOM + off;
    end

    jit = 1'b0;
    run_cycle(-1, 3, on, len, lr);
    check("R8 period before disable takes effect", len, exp_p);
    for (int i = 0; i < 2; i++) begin
      run_cycle(-1, 3, on, len, lr);
      check("R8 nominal after disable", len, NOM);
    end
    jit = 1'b1;
    run_cycle(-1, 3, on, len, lr);
    check("R8 enable cycle nominal", len, NOM);
    run_cycle(-1, 3, on, len, lr);
    check("R8 restart upward", len, NOM + 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule